// File: doc/BRIEF.md
# Sleep Mode Entry and Exit Sequencer

This block steps a processor subsystem in and out of four sleep levels and drives the control lines that the rest of the chip uses to gate clocks, power down peripherals, keep memory alive and freeze pad states. Software writes a mode request. A request with the top bit clear picks a new run mode (core voltage level and switching-regulator choice). A request with the top bit set asks for one of the sleep levels. Two enable inputs say whether the real-time counter and the watchdog should keep running while asleep. A wake input ends sleep.

The two deep-sleep levels keep all state. A wake from either one resumes the run mode that was in force when sleep began. The two shutdown levels drop most state. A wake from either one is a restart into the default run mode, and a two-bit flag then tells software which shutdown level it came back from. Entry and exit each pass through one clock of clocks-only gating, so clock gating always encloses the power and retention controls.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: Reset leaves the block in the run state with run mode 00, no exit flag, clocks and pads free, SRAM retention lines high, regulator enabled and switching regulator deselected.
- R2: A request (`req_valid` high) is taken only in the run state. `req_mode` values 0 to 3 set the run mode: bit 1 selects the switching regulator and bit 0 the core voltage level. Values 4, 5, 6 and 7 ask for light deep sleep, deep sleep, light shutdown and deep shutdown. A request made in any other state has no effect, and neither does a wake in the run state.
- R3: A light deep sleep request made while both `rtc_en` and `wdt_en` are low enters deep sleep instead (`mode_now` = 101).
- R4: In light deep sleep and in light shutdown, the real-time counter and watchdog run lines hold the enables sampled at entry. The low-frequency clock stays on only if one of them is set. In every other sleep level both run lines and all clocks are off. The high-frequency clock is off in every sleep level.
- R5: Outside the run state the switching regulator is deselected.
- R6: In both deep-sleep levels, all SRAM retention lines stay high, peripherals stay powered, the regulator stays on and pads are latched.
- R7: In light shutdown, peripherals are powered down, the core voltage level is forced to 0, only SRAM bank 0 is retained and pads are latched.
- R8: In deep shutdown, the regulator and all SRAM retention are off, peripherals are powered down and pads are latched.
- R9: A wake from either deep-sleep level restores the run mode held at entry.
- R10: A wake from a shutdown level returns to run mode 00 and sets `shut_exit` to 01 (light) or 10 (deep). The next accepted sleep request clears the flag.
- R11: On entry, clocks are gated one cycle before the power and retention controls apply. On exit, the power and retention controls release one cycle before the clocks do.
- R12: A wake during the one-cycle clock-gating step of entry aborts the entry. The block returns to run on the next edge and never applies the power controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 3 | Requested mode code |
| rtc_en | input | 1 | Real-time counter enable |
| wdt_en | input | 1 | Watchdog enable |
| wake | input | 1 | Wake event |
| hf_clk_off | output | 1 | High-frequency clocks gated |
| lf_clk_off | output | 1 | Low-frequency clocks gated |
| rtc_run | output | 1 | Real-time counter allowed to run |
| wdt_run | output | 1 | Watchdog allowed to run |
| periph_pd | output | 1 | Peripheral power-down |
| sram_b0_ret | output | 1 | SRAM bank 0 kept powered |
| sram_bn_ret | output | 1 | Other SRAM banks kept powered |
| io_latch | output | 1 | Pad states frozen |
| reg_en | output | 1 | Internal regulator enabled |
| dcdc_sel | output | 1 | Switching regulator selected |
| vcore_lvl | output | 1 | Core voltage level |
| mode_now | output | 3 | Run mode {0,mode} or sleep level {1,level} |
| in_sleep | output | 1 | Power controls applied |
| shut_exit | output | 2 | Shutdown level last exited |

## Verification
The wake input and sleep entry can land in the same cycle in two ways. A wake can arrive in the clock-gating step just after a request is taken, which must abort the entry. A wake can also arrive together with a request while the block is in the run state, where the wake must be ignored and the request accepted. Directed sequences set up both cases on purpose, and random traffic with frequent wakes makes them happen many more times. Every output is compared in every cycle against a model of the requirements kept in the bench, so an abort that briefly applies retention or power-down shows up as a mismatch.

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_mode,
  input  logic       rtc_en,
  input  logic       wdt_en,
  input  logic       wake,
  output logic       hf_clk_off,
  output logic       lf_clk_off,
  output logic       rtc_run,
  output logic       wdt_run,
  output logic       periph_pd,
  output logic       sram_b0_ret,
  output logic       sram_bn_ret,
  output logic       io_latch,
  output logic       reg_en,
  output logic       dcdc_sel,
  output logic       vcore_lvl,
  output logic [2:0] mode_now,
  output logic       in_sleep,
  output logic [1:0] shut_exit
);
  typedef enum logic [1:0] {S_RUN, S_GATE, S_SLEEP, S_UNGATE} st_t;
  localparam logic [1:0] L_LDS = 2'd0, L_DS = 2'd1, L_LSD = 2'd2, L_DSD = 2'd3;

  st_t        st;
  logic [1:0] lvl, run_mode;
  logic       kept_rtc, kept_wdt;

  wire take      = (st == S_RUN) && req_valid;
  wire go_sleep  = take && req_mode[2];
  wire promote   = (req_mode[1:0] == L_LDS) && !rtc_en && !wdt_en;
  wire gated     = (st != S_RUN);
  wire pwr       = (st == S_SLEEP);
  wire lf_level  = (lvl == L_LDS) || (lvl == L_LSD);
  wire keep_rtc  = kept_rtc && lf_level;
  wire keep_wdt  = kept_wdt && lf_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      lvl       <= L_LDS;
      run_mode  <= 2'b00;
      kept_rtc  <= 1'b0;
      kept_wdt  <= 1'b0;
      shut_exit <= 2'b00;
    end else begin
      case (st)
        S_RUN: begin
          if (take && !req_mode[2]) run_mode <= req_mode[1:0];
          if (go_sleep) begin
            lvl       <= promote ? L_DS : req_mode[1:0];
            kept_rtc  <= rtc_en;
            kept_wdt  <= wdt_en;
            shut_exit <= 2'b00;
            st        <= S_GATE;
          end
        end
        S_GATE:  st <= wake ? S_RUN : S_SLEEP;
        S_SLEEP: if (wake) st <= S_UNGATE;
        S_UNGATE: begin
          if (lvl[1]) begin
            run_mode  <= 2'b00;
            shut_exit <= (lvl == L_DSD) ? 2'b10 : 2'b01;
          end
          st <= S_RUN;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign hf_clk_off  = gated;
  assign lf_clk_off  = gated && !(keep_rtc || keep_wdt);
  assign rtc_run     = gated ? keep_rtc : rtc_en;
  assign wdt_run     = gated ? keep_wdt : wdt_en;
  assign periph_pd   = pwr && lvl[1];
  assign sram_b0_ret = !(pwr && lvl == L_DSD);
  assign sram_bn_ret = !(pwr && lvl[1]);
  assign io_latch    = pwr;
  assign reg_en      = !(pwr && lvl == L_DSD);
  assign dcdc_sel    = !gated && run_mode[1];
  assign vcore_lvl   = (pwr && lvl == L_LSD) ? 1'b0 : run_mode[0];
  assign mode_now    = gated ? {1'b1, lvl} : {1'b0, run_mode};
  assign in_sleep    = pwr;

  a_r3_promote: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && req_valid && req_mode == 3'b100 && !rtc_en && !wdt_en) |=> mode_now == 3'b101);
  a_r12_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GATE && wake) |=> (!hf_clk_off && !io_latch));
  a_r11_entry_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_latch) |-> $past(hf_clk_off));
  a_r11_exit_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_latch) |-> hf_clk_off);
  a_r5_no_dcdc: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep |-> !dcdc_sel);
  a_r9_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UNGATE && !lvl[1]) |=> mode_now[1:0] == $past(run_mode));
  a_r10_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UNGATE && lvl == L_DSD) |=> (shut_exit == 2'b10 && mode_now == 3'b000));
  a_r8_dsd: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && mode_now == 3'b111) |-> (!reg_en && !sram_b0_ret && lf_clk_off));
endmodule

// File: tb/lpm_seq_ctrl_tb.sv
module lpm_seq_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rtc_en = 1'b0, wdt_en = 1'b0, wake = 1'b0;
  logic [2:0] req_mode = 3'd0;
  logic hf_clk_off, lf_clk_off, rtc_run, wdt_run, periph_pd, sram_b0_ret, sram_bn_ret;
  logic io_latch, reg_en, dcdc_sel, vcore_lvl, in_sleep;
  logic [2:0] mode_now;
  logic [1:0] shut_exit;

  always #2.5 clk = ~clk;

  lpm_seq_ctrl dut_i (.*);

  int n_chk = 0, n_bad = 0;
  int m_ph = 0;
  logic [1:0] m_t = 0, m_am = 0, m_fl = 0;
  logic m_r = 0, m_w = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic lfk(logic [1:0] t);
    return (t == 2'd0) || (t == 2'd2);
  endfunction

  task automatic model_step(logic v, logic [2:0] m, logic r, logic w, logic wk);
    case (m_ph)
      0: if (v) begin
           if (!m[2]) m_am = m[1:0];
           else begin
             m_t  = (m == 3'd4 && !r && !w) ? 2'd1 : m[1:0];
             m_r  = r; m_w = w; m_fl = 2'd0; m_ph = 1;
           end
         end
      1: m_ph = wk ? 0 : 2;
      2: if (wk) m_ph = 3;
      default: begin
        if (m_t[1]) begin m_fl = (m_t == 2'd3) ? 2'd2 : 2'd1; m_am = 2'd0; end
        m_ph = 0;
      end
    endcase
  endtask

  task automatic compare_all();
    logic g, p, kr, kw;
    g  = (m_ph != 0);
    p  = (m_ph == 2);
    kr = m_r && lfk(m_t);
    kw = m_w && lfk(m_t);
    chk("R4 hf_clk_off", hf_clk_off, g);
    chk("R4 lf_clk_off", lf_clk_off, g && !(kr || kw));
    chk("R4 rtc_run", rtc_run, g ? kr : rtc_en);
    chk("R4 wdt_run", wdt_run, g ? kw : wdt_en);
    chk("R7 periph_pd", periph_pd, p && m_t[1]);
    chk("R8 sram_b0_ret", sram_b0_ret, !(p && m_t == 2'd3));
    chk("R6 sram_bn_ret", sram_bn_ret, !(p && m_t[1]));
    chk("R11 io_latch", io_latch, p);
    chk("R8 reg_en", reg_en, !(p && m_t == 2'd3));
    chk("R5 dcdc_sel", dcdc_sel, !g && m_am[1]);
    chk("R7 vcore_lvl", vcore_lvl, (p && m_t == 2'd2) ? 1'b0 : m_am[0]);
    chk("R2 mode_now", mode_now, g ? {1'b1, m_t} : {1'b0, m_am});
    chk("R11 in_sleep", in_sleep, p);
    chk("R10 shut_exit", shut_exit, m_fl);
  endtask

  task automatic cyc(logic v, logic [2:0] m, logic r, logic w, logic wk);
    req_valid = v; req_mode = m; rtc_en = r; wdt_en = w; wake = wk;
    @(negedge clk);
    model_step(v, m, r, w, wk);
    compare_all();
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode_now", mode_now, 0);
    chk("R1 reg_en", reg_en, 1);
    chk("R1 sram_bn_ret", sram_bn_ret, 1);
    chk("R1 hf_clk_off", hf_clk_off, 0);
    chk("R1 shut_exit", shut_exit, 0);
    compare_all();

    // R3 promotion, R9 resume of run mode 11
    cyc(1, 3'd3, 0, 0, 0);
    cyc(1, 3'd4, 0, 0, 0);
    chk("R3 promoted level", mode_now, 5);
    chk("R11 clocks first", {hf_clk_off, io_latch}, 2'b10);
    cyc(0, 0, 0, 0, 0);
    chk("R6 sleeping", {in_sleep, sram_b0_ret, sram_bn_ret, reg_en, periph_pd}, 5'b11110);
    cyc(1, 3'd0, 0, 0, 1);
    chk("R11 power released first", {io_latch, hf_clk_off}, 2'b01);
    cyc(0, 0, 0, 0, 0);
    chk("R9 resumed run mode", mode_now, 3);

    // R12 abort during gating step
    cyc(1, 3'd4, 1, 0, 0);
    cyc(0, 0, 1, 0, 1);
    chk("R12 abort to run", {hf_clk_off, io_latch, mode_now}, 5'b00011);

    // R2 wake with request in run state, R7 light shutdown
    cyc(1, 3'd6, 0, 1, 1);
    chk("R2 request taken despite wake", mode_now, 6);
    cyc(0, 0, 0, 0, 0);
    chk("R7 light shutdown", {vcore_lvl, sram_b0_ret, sram_bn_ret, wdt_run, lf_clk_off}, 5'b01010);
    cyc(1, 3'd1, 0, 0, 0);
    chk("R2 request ignored asleep", mode_now, 6);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0);
    chk("R10 light shutdown exit", {shut_exit, mode_now}, 5'b01000);

    // R8 deep shutdown
    cyc(1, 3'd7, 1, 1, 0);
    cyc(0, 0, 1, 1, 0);
    chk("R8 deep shutdown", {reg_en, sram_b0_ret, lf_clk_off, rtc_run}, 4'b0010);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0);
    chk("R10 deep shutdown exit", shut_exit, 2);

    for (int i = 0; i < 20000; i++) begin
      cyc(($urandom % 3) == 0, 3'($urandom), 1'($urandom), 1'($urandom), ($urandom % 5) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule